// File: doc/BRIEF.md
# ATM Receive Cell Buffer with Cell-Level Handshake

This block sits on the physical-layer side of a receive path and buffers complete ATM cells for a cell-layer reader. A line-side producer presents octets one per cycle with a valid strobe and marks the first octet of every cell. The octets land in a fixed number of cell slots. The read side is a UTOPIA-style port. It has an active-low read enable, a 16-bit data bus, a start-of-cell output and a cell-available output. The reader waits for cell-available and then pulls words back to back.

A small control word selects the bus width and the cell length. An 8-bit bus carries one octet per word. A 16-bit bus carries two octets per word, and the earlier octet sits in the upper byte. A length code that is not legal for the selected width falls back to 52 octets and raises a configuration error. When every slot holds a complete cell, a newly started cell is discarded as a whole and a sticky overflow flag is set. The configuration is assumed static while cells are stored.

Top module: `utopia_rx_cell_fifo`

## Requirements
- R1: The width code is `cfg_ctrl[3:2]`: 00 selects an 8-bit bus and 01 a 16-bit bus. The length code is `cfg_ctrl[1:0]`: 00 gives 52 octets, 01 gives 53 octets (8-bit bus only) and 10 gives 54 octets (16-bit bus only).
- R2: A width code of 1x acts as an 8-bit bus. Length code 11, code 01 on a 16-bit bus and code 10 on an 8-bit bus all give 52 octets. `cfg_err` is 1 for any such illegal setting and 0 for a legal one.
- R3: `rd_cav` is 1 exactly when at least one completely written cell is stored. It rises in the cycle after the final octet of a cell is accepted. A cell that is only partly written never raises it.
- R4: When the last word of the last stored cell is read, `rd_cav` is 0 in the next cycle.
- R5: When `rd_en_n` is low at a clock edge and `rd_cav` is 1, the next word of the oldest cell appears on `rd_data` after that edge. `rd_soc` is 1 with the first word of each cell and 0 at all other times.
- R6: On an 8-bit bus each word carries one octet in `rd_data[7:0]`, with `rd_data[15:8]` at zero, and a cell takes as many words as it has octets.
- R7: On a 16-bit bus `rd_data[15:8]` holds the earlier octet and `rd_data[7:0]` the later one. A 52-octet cell takes 26 words and a 54-octet cell takes 27 words.
- R8: The buffer holds 4 complete cells. A cell whose first octet arrives while all 4 are stored is dropped entirely, and the stored cells are not affected. The drop sets `ovf_flag`, which stays 1 until reset.
- R9: An octet with `wr_sop` high always starts a new cell and discards any partial one. An octet with `wr_sop` low arriving while no cell is in progress is ignored.
- R10: `rd_en_n` low while `rd_cav` is 0 consumes nothing: `rd_data` holds its value and `rd_soc` stays 0.
- R11: After reset `rd_cav`, `rd_soc`, `ovf_flag` and `rd_data` are all 0.
- R12: Cells are read out in the order their writes completed, with octets in arrival order, and this holds even when reads and writes overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low reset |
| cfg_ctrl | input | 4 | [3:2] bus width code, [1:0] cell length code |
| wr_valid | input | 1 | Line-side octet valid |
| wr_sop | input | 1 | Marks the first octet of a cell |
| wr_data | input | 8 | Line-side octet |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | 16 | Read data word |
| rd_soc | output | 1 | First word of a cell is on `rd_data` |
| rd_cav | output | 1 | At least one complete cell is available |
| ovf_flag | output | 1 | Sticky: a cell was dropped for lack of space |
| cfg_err | output | 1 | The control word holds an illegal combination |

## Verification
A wrong stored-cell count shows on `rd_cav` in the cycle after the edge that moved it. It appears either as an early rise before the last octet of a cell or as a missing fall after the last word. The bench samples `rd_cav` on both sides of those edges for every length and width. A wrong write offset or slot pointer corrupts cell data. A wrong read word counter moves `rd_soc` or changes the words-per-cell count. Both surface at the latest by the end of the next cell, because the bench compares every word, in every configuration, with an arithmetic pattern.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;

   localparam int unsigned OCT_W     = 8;
   localparam int unsigned BUS_W     = 2 * OCT_W;
   localparam int unsigned LEN_BASE  = 52;
   localparam int unsigned LEN_HEC   = 53;
   localparam int unsigned LEN_STUFF = 54;
   localparam int unsigned LEN_MAX   = LEN_STUFF;
   localparam int unsigned LEN_W     = $clog2(LEN_MAX + 1);

   typedef enum logic [1:0] {
      SZ_BASE  = 2'b00,
      SZ_HEC   = 2'b01,
      SZ_STUFF = 2'b10,
      SZ_RSVD  = 2'b11
   } size_code_e;

   typedef enum logic [1:0] {
      BW_8    = 2'b00,
      BW_16   = 2'b01,
      BW_RSV2 = 2'b10,
      BW_RSV3 = 2'b11
   } width_code_e;

   typedef struct packed {
      logic             wide;
      logic [LEN_W-1:0] cell_len;
      logic [LEN_W-1:0] cell_words;
      logic             err;
   } cell_cfg_t;

endpackage

// File: rtl/ucf_cfg_dec.sv
module ucf_cfg_dec
   import utopia_rx_pkg::*;
(
   input  logic [3:0] ctrl,
   output cell_cfg_t  cfg
);

   size_code_e       size;
   width_code_e      wcode;
   logic             wide;
   logic             size_bad;
   logic [LEN_W-1:0] len;

   always_comb begin
      size     = size_code_e'(ctrl[1:0]);
      wcode    = width_code_e'(ctrl[3:2]);
      wide     = (wcode == BW_16);
      size_bad = 1'b0;
      len      = LEN_W'(LEN_BASE);
      unique case (size)
         SZ_BASE:  len = LEN_W'(LEN_BASE);
         SZ_HEC: begin
            if (wide) size_bad = 1'b1;
            else      len      = LEN_W'(LEN_HEC);
         end
         SZ_STUFF: begin
            if (wide) len      = LEN_W'(LEN_STUFF);
            else      size_bad = 1'b1;
         end
         SZ_RSVD:  size_bad = 1'b1;
      endcase
      cfg.wide       = wide;
      cfg.cell_len   = len;
      cfg.cell_words = wide ? (len >> 1) : len;
      cfg.err        = size_bad | (wcode == BW_RSV2) | (wcode == BW_RSV3);
   end

endmodule

// File: rtl/ucf_store.sv
module ucf_store
   import utopia_rx_pkg::*;
#(
   parameter int unsigned DEPTH = 216,
   localparam int unsigned AW   = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [OCT_W-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [OCT_W-1:0] rd_first,
   output logic [OCT_W-1:0] rd_second
);

   logic [OCT_W-1:0] mem [DEPTH];
   logic [AW-1:0]    raddr_nxt;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign raddr_nxt = (raddr == AW'(DEPTH - 1)) ? '0 : raddr + AW'(1);
   assign rd_first  = mem[raddr];
   assign rd_second = mem[raddr_nxt];

endmodule

// File: rtl/ucf_wr_ctrl.sv
module ucf_wr_ctrl
   import utopia_rx_pkg::*;
#(
   parameter int unsigned SLOTS = 4,
   localparam int unsigned SW   = $clog2(SLOTS),
   localparam int unsigned CW   = $clog2(SLOTS + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] cell_len,
   input  logic [CW-1:0]    stored_cnt,
   input  logic             wr_valid,
   input  logic             wr_sop,
   input  logic [OCT_W-1:0] wr_data,
   output logic             mem_we,
   output logic [SW-1:0]    mem_slot,
   output logic [LEN_W-1:0] mem_off,
   output logic [OCT_W-1:0] mem_data,
   output logic             commit,
   output logic             ovf
);

   logic             active_q;
   logic [LEN_W-1:0] off_q;
   logic [SW-1:0]    slot_q;
   logic             has_room;
   logic             start_cell;
   logic             drop_cell;
   logic             cont_cell;
   logic             last_oct;

   always_comb begin
      has_room   = (stored_cnt < CW'(SLOTS));
      start_cell = wr_valid & wr_sop & has_room;
      drop_cell  = wr_valid & wr_sop & ~has_room;
      cont_cell  = wr_valid & ~wr_sop & active_q;
      last_oct   = cont_cell & (off_q == cell_len - LEN_W'(1));
   end

   assign mem_we   = start_cell | cont_cell;
   assign mem_off  = start_cell ? '0 : off_q;
   assign mem_slot = slot_q;
   assign mem_data = wr_data;
   assign commit   = last_oct;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         off_q    <= '0;
         slot_q   <= '0;
         ovf      <= 1'b0;
      end else if (start_cell) begin
         active_q <= 1'b1;
         off_q    <= LEN_W'(1);
      end else if (drop_cell) begin
         active_q <= 1'b0;
         off_q    <= '0;
         ovf      <= 1'b1;
      end else if (last_oct) begin
         active_q <= 1'b0;
         off_q    <= '0;
         slot_q   <= (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + SW'(1);
      end else if (cont_cell) begin
         off_q    <= off_q + LEN_W'(1);
      end
   end

endmodule

// File: rtl/ucf_rd_ctrl.sv
module ucf_rd_ctrl
   import utopia_rx_pkg::*;
#(
   parameter int unsigned SLOTS = 4,
   localparam int unsigned SW   = $clog2(SLOTS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wide,
   input  logic [LEN_W-1:0] cell_words,
   input  logic             cav,
   input  logic             rd_en_n,
   input  logic [OCT_W-1:0] oct_first,
   input  logic [OCT_W-1:0] oct_second,
   output logic [SW-1:0]    mem_slot,
   output logic [LEN_W-1:0] mem_off,
   output logic             release_cell,
   output logic [BUS_W-1:0] rd_data,
   output logic             rd_soc
);

   logic [LEN_W-1:0] word_q;
   logic [SW-1:0]    slot_q;
   logic             fire;
   logic             last_word;

   assign fire         = ~rd_en_n & cav;
   assign last_word    = (word_q == cell_words - LEN_W'(1));
   assign release_cell = fire & last_word;
   assign mem_slot     = slot_q;
   assign mem_off      = wide ? {word_q[LEN_W-2:0], 1'b0} : word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         slot_q  <= '0;
         rd_data <= '0;
         rd_soc  <= 1'b0;
      end else begin
         rd_soc <= fire & (word_q == '0);
         if (fire) begin
            rd_data <= wide ? {oct_first, oct_second} : {{OCT_W{1'b0}}, oct_first};
            if (last_word) begin
               word_q <= '0;
               slot_q <= (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + SW'(1);
            end else begin
               word_q <= word_q + LEN_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/utopia_rx_cell_fifo.sv
module utopia_rx_cell_fifo
   import utopia_rx_pkg::*;
#(
   parameter int unsigned CELL_SLOTS = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       cfg_ctrl,
   input  logic             wr_valid,
   input  logic             wr_sop,
   input  logic [OCT_W-1:0] wr_data,
   input  logic             rd_en_n,
   output logic [BUS_W-1:0] rd_data,
   output logic             rd_soc,
   output logic             rd_cav,
   output logic             ovf_flag,
   output logic             cfg_err
);

   localparam int unsigned DEPTH = CELL_SLOTS * LEN_MAX;
   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned SW    = $clog2(CELL_SLOTS);
   localparam int unsigned CW    = $clog2(CELL_SLOTS + 1);

   if (CELL_SLOTS < 2) begin : g_bad_slots
      $error("CELL_SLOTS must be at least 2");
   end
   if (CELL_SLOTS > 64) begin : g_big_slots
      $error("CELL_SLOTS above 64 is not supported");
   end

   cell_cfg_t        cfg;
   logic [CW-1:0]    cell_cnt;
   logic             commit;
   logic             release_cell;
   logic             mem_we;
   logic [SW-1:0]    w_slot;
   logic [SW-1:0]    r_slot;
   logic [LEN_W-1:0] w_off;
   logic [LEN_W-1:0] r_off;
   logic [OCT_W-1:0] w_data;
   logic [OCT_W-1:0] oct_first;
   logic [OCT_W-1:0] oct_second;
   logic [AW-1:0]    slot_base [CELL_SLOTS];
   logic [AW-1:0]    waddr;
   logic [AW-1:0]    raddr;

   for (genvar g = 0; g < CELL_SLOTS; g++) begin : g_base
      assign slot_base[g] = AW'(g * LEN_MAX);
   end

   assign waddr   = slot_base[w_slot] + AW'(w_off);
   assign raddr   = slot_base[r_slot] + AW'(r_off);
   assign rd_cav  = (cell_cnt != '0);
   assign cfg_err = cfg.err;

   ucf_cfg_dec u_cfg (
      .ctrl (cfg_ctrl),
      .cfg  (cfg)
   );

   ucf_wr_ctrl #(.SLOTS(CELL_SLOTS)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .cell_len   (cfg.cell_len),
      .stored_cnt (cell_cnt),
      .wr_valid   (wr_valid),
      .wr_sop     (wr_sop),
      .wr_data    (wr_data),
      .mem_we     (mem_we),
      .mem_slot   (w_slot),
      .mem_off    (w_off),
      .mem_data   (w_data),
      .commit     (commit),
      .ovf        (ovf_flag)
   );

   ucf_store #(.DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .we        (mem_we),
      .waddr     (waddr),
      .wdata     (w_data),
      .raddr     (raddr),
      .rd_first  (oct_first),
      .rd_second (oct_second)
   );

   ucf_rd_ctrl #(.SLOTS(CELL_SLOTS)) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .wide         (cfg.wide),
      .cell_words   (cfg.cell_words),
      .cav          (rd_cav),
      .rd_en_n      (rd_en_n),
      .oct_first    (oct_first),
      .oct_second   (oct_second),
      .mem_slot     (r_slot),
      .mem_off      (r_off),
      .release_cell (release_cell),
      .rd_data      (rd_data),
      .rd_soc       (rd_soc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cell_cnt <= '0;
      end else begin
         unique case ({commit, release_cell})
            2'b10:   cell_cnt <= cell_cnt + CW'(1);
            2'b01:   cell_cnt <= cell_cnt - CW'(1);
            default: cell_cnt <= cell_cnt;
         endcase
      end
   end

endmodule

// File: rtl/ucf_chk.sv
module ucf_chk #(
   parameter int unsigned SLOTS = 4,
   localparam int unsigned CW   = $clog2(SLOTS + 1)
)(
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    cfg_ctrl,
   input logic          wr_valid,
   input logic          rd_en_n,
   input logic          rd_soc,
   input logic          rd_cav,
   input logic          ovf_flag,
   input logic          cfg_err,
   input logic [CW-1:0] cell_cnt
);

   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cell_cnt <= CW'(SLOTS));

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   p_cav_rise_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_cav) |-> $past(wr_valid));

   p_cav_fall_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_cav) |-> $past(!rd_en_n));

   p_soc_needs_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_soc |-> $past(!rd_en_n && rd_cav));

   p_soc_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_soc |=> !rd_soc);

   p_rsvd_size_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ctrl[1:0] == 2'b11) |-> cfg_err);

   p_legal_no_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ctrl == 4'b0000 || cfg_ctrl == 4'b0001 || cfg_ctrl == 4'b0110) |-> !cfg_err);

endmodule

bind utopia_rx_cell_fifo ucf_chk #(.SLOTS(CELL_SLOTS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_ctrl (cfg_ctrl),
   .wr_valid (wr_valid),
   .rd_en_n  (rd_en_n),
   .rd_soc   (rd_soc),
   .rd_cav   (rd_cav),
   .ovf_flag (ovf_flag),
   .cfg_err  (cfg_err),
   .cell_cnt (cell_cnt)
);

// File: tb/utopia_rx_cell_fifo_bench.sv
module utopia_rx_cell_fifo_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_ctrl = 4'h0;
   logic        wr_valid = 1'b0;
   logic        wr_sop = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic        rd_en_n = 1'b1;
   logic [15:0] rd_data;
   logic        rd_soc;
   logic        rd_cav;
   logic        ovf_flag;
   logic        cfg_err;

   int checks = 0;
   int errors = 0;
   int stored = 0;

   always #2 clk = ~clk;

   utopia_rx_cell_fifo u_utopia_rx_cell_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_ctrl (cfg_ctrl),
      .wr_valid (wr_valid),
      .wr_sop   (wr_sop),
      .wr_data  (wr_data),
      .rd_en_n  (rd_en_n),
      .rd_data  (rd_data),
      .rd_soc   (rd_soc),
      .rd_cav   (rd_cav),
      .ovf_flag (ovf_flag),
      .cfg_err  (cfg_err)
   );

   function automatic logic [7:0] pat(int tag, int i);
      return 8'((tag * 37 + i * 3 + 1) & 255);
   endfunction

   function automatic bit is_wide(logic [3:0] c);
      return c[3:2] == 2'b01;
   endfunction

   function automatic int exp_len(logic [3:0] c);
      bit w = is_wide(c);
      case (c[1:0])
         2'b01:   return w ? 52 : 53;
         2'b10:   return w ? 54 : 52;
         default: return 52;
      endcase
   endfunction

   function automatic bit exp_err(logic [3:0] c);
      bit w = is_wide(c);
      return c[3] || (c[1:0] == 2'b11) || (c[1:0] == 2'b01 && w) || (c[1:0] == 2'b10 && !w);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic write_cell(int tag, int len, bit commits, bit do_chk);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         wr_valid = 1'b1;
         wr_sop   = (i == 0);
         wr_data  = pat(tag, i);
         if (do_chk && i == len - 1)
            chk("R3", rd_cav, stored != 0, "cav before last octet");
      end
      @(negedge clk);
      wr_valid = 1'b0;
      wr_sop   = 1'b0;
      if (commits) stored++;
      if (do_chk) chk("R3", rd_cav, 1, "cav after last octet");
   endtask

   task automatic read_cell(int tag, int len, bit wide, bit do_chk);
      int words = wide ? len / 2 : len;
      @(negedge clk);
      rd_en_n = 1'b0;
      for (int w = 0; w < words; w++) begin
         logic [15:0] e;
         @(negedge clk);
         e = wide ? {pat(tag, 2 * w), pat(tag, 2 * w + 1)} : {8'h00, pat(tag, w)};
         chk(wide ? "R7" : "R6", rd_data, e, "data word (R12 order)");
         chk("R5", rd_soc, w == 0, "soc");
         if (w == words - 1) begin
            rd_en_n = 1'b1;
            stored--;
            if (do_chk) chk("R4", rd_cav, stored != 0, "cav after last word");
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] held;
      logic [3:0]  cfgs [9] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h9};

      repeat (3) @(negedge clk);
      chk("R11", rd_cav, 0, "cav in reset");
      chk("R11", ovf_flag, 0, "ovf in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", rd_cav, 0, "cav after reset");
      chk("R11", rd_soc, 0, "soc after reset");
      chk("R11", rd_data, 0, "data after reset");
      chk("R11", ovf_flag, 0, "ovf after reset");

      // R1 R2: error flag over every control value
      for (int c = 0; c < 16; c++) begin
         cfg_ctrl = 4'(c);
         #1;
         chk("R2", cfg_err, exp_err(4'(c)), $sformatf("cfg_err ctrl=%0h", c));
      end

      // R1 R2 R6 R7: cell length and word packing per configuration
      for (int k = 0; k < 9; k++) begin
         cfg_ctrl = cfgs[k];
         write_cell(k * 2, exp_len(cfgs[k]), 1, 1);
         write_cell(k * 2 + 1, exp_len(cfgs[k]), 1, 1);
         read_cell(k * 2, exp_len(cfgs[k]), is_wide(cfgs[k]), 1);
         read_cell(k * 2 + 1, exp_len(cfgs[k]), is_wide(cfgs[k]), 1);
      end

      // R9: stray octets ignored, sop restarts a partial cell
      cfg_ctrl = 4'h0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); wr_valid = 1'b1; wr_sop = 1'b0; wr_data = 8'hEE;
      end
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); wr_valid = 1'b1; wr_sop = (i == 0); wr_data = pat(30, i);
      end
      @(negedge clk); wr_valid = 1'b0; wr_sop = 1'b0;
      chk("R9", rd_cav, 0, "cav after stray and partial octets");
      write_cell(31, 52, 1, 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); wr_valid = 1'b1; wr_sop = 1'b0; wr_data = 8'hDD;
      end
      @(negedge clk); wr_valid = 1'b0;
      read_cell(31, 52, 0, 1);
      chk("R9", rd_cav, 0, "no extra cell from trailing octets");

      // R12: overlapping read and write on a 16-bit bus
      cfg_ctrl = 4'h6;
      write_cell(20, 54, 1, 1);
      write_cell(21, 54, 1, 1);
      fork
         write_cell(22, 54, 1, 0);
         read_cell(20, 54, 1, 0);
      join
      read_cell(21, 54, 1, 1);
      read_cell(22, 54, 1, 1);

      // R8: capacity and whole-cell drop
      cfg_ctrl = 4'h0;
      for (int t = 40; t < 44; t++) write_cell(t, 52, 1, 1);
      chk("R8", ovf_flag, 0, "ovf with 4 cells stored");
      write_cell(44, 52, 0, 0);
      chk("R8", ovf_flag, 1, "ovf after drop");
      for (int t = 40; t < 44; t++) read_cell(t, 52, 0, 1);
      chk("R8", rd_cav, 0, "dropped cell never available");
      chk("R8", ovf_flag, 1, "ovf sticky");

      // R10: read enable while empty
      held = rd_data;
      @(negedge clk); rd_en_n = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk("R10", rd_soc, 0, "soc on empty read");
         chk("R10", rd_data, held, "data holds on empty read");
      end
      rd_en_n = 1'b1;
      write_cell(50, 52, 1, 1);
      read_cell(50, 52, 0, 1);

      // R11: reset clears the sticky flag
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R11", ovf_flag, 0, "ovf cleared by reset");
      rst_n = 1'b1;
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule